// File: doc/BRIEF.md
# Event Permission Filter

This block holds one permission bit for every event number a performance counter may select. A counter asks it with an event number and gets back a permit bit that decides whether the counter is given a counting source. The host shapes the table with range commands. Each command carries a base event, a count and an action that either permits or forbids the whole range.

Until the first accepted command the filter is off and every event is permitted. The first accepted command first sets every entry to a default that depends on its own action. A permit-first command sets the default to forbidden, and a forbid-first command sets it to permitted. The range of that command is then applied on top. Later commands only touch their own range. Malformed commands are refused with an error pulse and change nothing.

The same table also trims the two 64-bit common-event capability words that software reads. The low half of a word takes its mask from events 0..31 (word 0) or 32..63 (word 1). The high half takes its mask from the window starting at event 0x4000 (word 0) or at 0x4020 (word 1). In word 1 the stall-slot event bit is cleared whenever the newer architecture revision is selected. Range commands walk the bitmap one 32-bit word per clock. Lookups wait while a command is in progress.

Top module: `efilt_top`

## Requirements
- R1: Out of reset, and until a command is accepted, every lookup returns permit 1, and the capability output equals the raw input except for the R10 bit.
- R2: A command whose action code is neither 2'b01 (permit) nor 2'b10 (forbid), or whose base+count exceeds 2^EVT_W, raises cmd_err for exactly the one cycle after acceptance. It changes no entry and does not turn the filter on.
- R3: A first accepted permit command makes every event outside its range forbidden and every event inside it permitted.
- R4: A first accepted forbid command makes every event outside its range permitted and every event inside it forbidden.
- R5: A later permit command sets the bits base..base+count-1 and a later forbid command clears them. Entries outside that range keep their value, and a count of zero changes nothing.
- R6: Ranges that start or end inside a 32-bit word change exactly the covered bits, including ranges that span several words and the range that ends at the last event 2^EVT_W-1.
- R7: After an accepted valid command, cmd_ready stays low for W+N+1 cycles. W is 2^EVT_W/32 on the first command and 0 otherwise. N is the number of 32-bit words the range touches. The trailing +1 is dropped when N is 0.
- R8: A lookup is accepted only while lk_ready is high, and a request raised during a command is held until the command ends. The result appears on lk_rsp_valid/lk_permit exactly one cycle after acceptance and reflects the table as it stood at acceptance.
- R9: When the filter is on, capability bit i of word s (cap_sel=s) is kept only if event 32*s+i is permitted (low half). Bit 32+i is kept only if event 0x4000+32*s+i is permitted (high half).
- R10: With ver_new high and cap_sel high, cap_out bit 31 (stall-slot event 63) is always 0.
- R11: Reset returns the filter to the off state of R1, whatever was programmed before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Range command request |
| cmd_ready | output | 1 | High when a command can be accepted |
| cmd_base | input | EVT_W | First event of the range |
| cmd_count | input | EVT_W+1 | Number of events in the range |
| cmd_act | input | 2 | 2'b01 permit, 2'b10 forbid, others invalid |
| cmd_err | output | 1 | One-cycle pulse: command refused |
| lk_req | input | 1 | Lookup request |
| lk_ready | output | 1 | High when a lookup can be accepted |
| lk_event | input | EVT_W | Event number to look up |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_permit | output | 1 | 1 = event may be counted |
| ver_new | input | 1 | Newer architecture revision selected |
| cap_sel | input | 1 | Capability word select (0 or 1) |
| cap_raw | input | 64 | Raw capability word |
| cap_out | output | 64 | Masked capability word |

## Verification
A lookup and a range command can be accepted on the same clock edge, since both see the idle state. The bench forks a forbid command and a lookup of an event inside that range so that both are driven on the same cycle. It then judges that the lookup result still carries the old permit value, and that a lookup issued right after the command returns the new one. A second case raises a lookup while a long command is walking the bitmap. It requires that the lookup was held for some cycles and that its answer includes the finished range.

// File: rtl/efilt_pkg.sv
package efilt_pkg;

  localparam int unsigned EF_WW        = 32;
  localparam int unsigned EF_BW        = 5;
  localparam int unsigned EF_HI_BASE   = 32'h4000;
  localparam int unsigned EF_STALL_EVT = 63;

  localparam logic [1:0] EF_ACT_PERMIT = 2'b01;
  localparam logic [1:0] EF_ACT_FORBID = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_RANGE = 2'd2,
    ST_DRAIN = 2'd3
  } ef_state_e;

  function automatic logic act_is_legal(input logic [1:0] act);
    return (act == EF_ACT_PERMIT) || (act == EF_ACT_FORBID);
  endfunction

  // Bits of bitmap word widx that fall inside the half-open range [lo, hi).
  function automatic logic [31:0] span_mask(input logic [31:0] widx,
                                            input logic [31:0] lo,
                                            input logic [31:0] hi);
    logic [31:0] m;
    logic [31:0] ev;
    for (int b = 0; b < 32; b++) begin
      ev   = (widx << EF_BW) + 32'(b);
      m[b] = (ev >= lo) && (ev < hi);
    end
    return m;
  endfunction

endpackage

// File: rtl/efilt_ram.sv
module efilt_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/efilt_seq.sv
module efilt_seq
  import efilt_pkg::*;
#(
  parameter int EVT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [EVT_W-1:0]   cmd_base,
  input  logic [EVT_W:0]     cmd_count,
  input  logic [1:0]         cmd_act,
  output logic               cmd_err,
  output logic               active,
  output logic               busy,
  output logic [EVT_W-6:0]   raddr,
  input  logic [31:0]        rdata,
  output logic               we,
  output logic [EVT_W-6:0]   waddr,
  output logic [31:0]        wdata
);
  localparam int WA = EVT_W - EF_BW;
  localparam logic [EVT_W+1:0] NEV_V = {2'b01, {EVT_W{1'b0}}};

  ef_state_e          st;
  logic [WA-1:0]      wcnt, wfirst, wlast, p_addr;
  logic [EVT_W:0]     lo, hi;
  logic               permit_q, def_one, p_vld;

  logic [EVT_W+1:0]   sum, sum_m1;
  logic               accept, legal;
  logic [31:0]        mask;

  assign sum    = {2'b00, cmd_base} + {1'b0, cmd_count};
  assign sum_m1 = sum - 1'b1;
  assign accept = cmd_valid && (st == ST_IDLE);
  assign legal  = act_is_legal(cmd_act) && (sum <= NEV_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      active   <= 1'b0;
      cmd_err  <= 1'b0;
      wcnt     <= '0;
      wfirst   <= '0;
      wlast    <= '0;
      lo       <= '0;
      hi       <= '0;
      permit_q <= 1'b0;
      def_one  <= 1'b0;
      p_vld    <= 1'b0;
      p_addr   <= '0;
    end else begin
      cmd_err <= 1'b0;
      p_vld   <= (st == ST_RANGE);
      p_addr  <= wcnt;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (!legal) begin
              cmd_err <= 1'b1;
            end else begin
              active   <= 1'b1;
              lo       <= {1'b0, cmd_base};
              hi       <= sum[EVT_W:0];
              permit_q <= (cmd_act == EF_ACT_PERMIT);
              def_one  <= (cmd_act == EF_ACT_FORBID);
              wfirst   <= cmd_base[EVT_W-1:EF_BW];
              wlast    <= sum_m1[EVT_W-1:EF_BW];
              if (!active) begin
                st   <= ST_FILL;
                wcnt <= '0;
              end else if (cmd_count != '0) begin
                st   <= ST_RANGE;
                wcnt <= cmd_base[EVT_W-1:EF_BW];
              end
            end
          end
        end
        ST_FILL: begin
          if (&wcnt) begin
            if (hi != lo) begin
              st   <= ST_RANGE;
              wcnt <= wfirst;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_RANGE: begin
          if (wcnt == wlast) st <= ST_DRAIN;
          else               wcnt <= wcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mask  = span_mask(32'(p_addr), 32'(lo), 32'(hi));
  assign busy  = (st != ST_IDLE);
  assign raddr = wcnt;
  assign we    = (st == ST_FILL) || p_vld;
  assign waddr = p_vld ? p_addr : wcnt;

  always_comb begin
    if (p_vld) wdata = permit_q ? (rdata | mask) : (rdata & ~mask);
    else       wdata = {32{def_one}};
  end
endmodule

// File: rtl/efilt_cap.sv
module efilt_cap
  import efilt_pkg::*;
#(
  parameter int EVT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [EVT_W-6:0]   waddr,
  input  logic [31:0]        wdata,
  input  logic               active,
  input  logic               ver_new,
  input  logic               cap_sel,
  input  logic [63:0]        cap_raw,
  output logic [63:0]        cap_out
);
  localparam int WA = EVT_W - EF_BW;
  localparam longint unsigned NEV = 64'(1) << EVT_W;
  localparam bit HAS_HI0 = NEV >= 64'(EF_HI_BASE + 32);
  localparam bit HAS_HI1 = NEV >= 64'(EF_HI_BASE + 64);

  logic [31:0] lo0_q, lo1_q, hi0_q, hi1_q;
  logic [63:0] win, keep_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo0_q <= '0;
      lo1_q <= '0;
    end else if (we) begin
      if (waddr == '0)        lo0_q <= wdata;
      if (waddr == WA'(1))    lo1_q <= wdata;
    end
  end

  if (HAS_HI0) begin : g_hi0
    localparam logic [WA-1:0] A_HI0 = WA'(EF_HI_BASE >> EF_BW);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      hi0_q <= '0;
      else if (we && waddr == A_HI0)   hi0_q <= wdata;
    end
  end else begin : g_nohi0
    assign hi0_q = '0;
  end

  if (HAS_HI1) begin : g_hi1
    localparam logic [WA-1:0] A_HI1 = WA'((EF_HI_BASE >> EF_BW) + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      hi1_q <= '0;
      else if (we && waddr == A_HI1)   hi1_q <= wdata;
    end
  end else begin : g_nohi1
    assign hi1_q = '0;
  end

  always_comb begin
    if (!active)      win = '1;
    else if (cap_sel) win = {hi1_q, lo1_q};
    else              win = {hi0_q, lo0_q};
    keep_stall = ~(64'(ver_new && cap_sel) << (EF_STALL_EVT - 32));
  end

  assign cap_out = cap_raw & win & keep_stall;
endmodule

// File: rtl/efilt_top.sv
module efilt_top
  import efilt_pkg::*;
#(
  parameter int EVT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [EVT_W-1:0]   cmd_base,
  input  logic [EVT_W:0]     cmd_count,
  input  logic [1:0]         cmd_act,
  output logic               cmd_err,
  input  logic               lk_req,
  output logic               lk_ready,
  input  logic [EVT_W-1:0]   lk_event,
  output logic               lk_rsp_valid,
  output logic               lk_permit,
  input  logic               ver_new,
  input  logic               cap_sel,
  input  logic [63:0]        cap_raw,
  output logic [63:0]        cap_out
);
  localparam int WA = EVT_W - EF_BW;

  logic            filt_on, seq_busy;
  logic [WA-1:0]   seq_raddr, ram_raddr, ram_waddr;
  logic [31:0]     ram_rdata, ram_wdata;
  logic            ram_we;
  logic            lk_take;
  logic            rsp_q, on_q;
  logic [EF_BW-1:0] bit_q;

  efilt_seq #(.EVT_W(EVT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_base(cmd_base), .cmd_count(cmd_count),
    .cmd_act(cmd_act), .cmd_err(cmd_err),
    .active(filt_on), .busy(seq_busy),
    .raddr(seq_raddr), .rdata(ram_rdata),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
  );

  assign ram_raddr = seq_busy ? seq_raddr : lk_event[EVT_W-1:EF_BW];

  efilt_ram #(.AW(WA), .DW(32)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  efilt_cap #(.EVT_W(EVT_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .active(filt_on), .ver_new(ver_new), .cap_sel(cap_sel),
    .cap_raw(cap_raw), .cap_out(cap_out)
  );

  assign cmd_ready = !seq_busy;
  assign lk_ready  = !seq_busy;
  assign lk_take   = lk_req && !seq_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
      on_q  <= 1'b0;
      bit_q <= '0;
    end else begin
      rsp_q <= lk_take;
      if (lk_take) begin
        on_q  <= filt_on;
        bit_q <= lk_event[EF_BW-1:0];
      end
    end
  end

  assign lk_rsp_valid = rsp_q;
  assign lk_permit    = !on_q || ram_rdata[bit_q];
endmodule

// File: rtl/efilt_chk.sv
module efilt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        cmd_err,
  input logic        lk_req,
  input logic        lk_ready,
  input logic        lk_rsp_valid,
  input logic        lk_permit,
  input logic        ver_new,
  input logic        cap_sel,
  input logic [63:0] cap_raw,
  input logic [63:0] cap_out,
  input logic        filt_on,
  input logic        seq_busy
);
  assert_err_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && cmd_ready));

  assert_err_no_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (filt_on == $past(filt_on)));

  assert_off_permits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rsp_valid && !filt_on) |-> lk_permit);

  assert_off_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_on && !cap_sel) |-> (cap_out == cap_raw));

  assert_rsp_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid |-> $past(lk_req && lk_ready));

  assert_busy_from_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> $past(cmd_valid && cmd_ready));

  assert_stall_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ver_new && cap_sel) |-> !cap_out[31]);

  assert_on_until_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    filt_on |=> filt_on);
endmodule

bind efilt_top efilt_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
  .lk_req(lk_req), .lk_ready(lk_ready),
  .lk_rsp_valid(lk_rsp_valid), .lk_permit(lk_permit),
  .ver_new(ver_new), .cap_sel(cap_sel), .cap_raw(cap_raw), .cap_out(cap_out),
  .filt_on(filt_on), .seq_busy(seq_busy)
);

// File: tb/tb_efilt_top.sv
`timescale 1ns/1ps
module tb_efilt_top;
  localparam int EW  = 16;
  localparam int NWD = (1 << EW) / 32;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready, cmd_err;
  logic [EW-1:0] cmd_base = '0;
  logic [EW:0]   cmd_count = '0;
  logic [1:0]    cmd_act = '0;
  logic lk_req = 0, lk_ready, lk_rsp_valid, lk_permit;
  logic [EW-1:0] lk_event = '0;
  logic ver_new = 0, cap_sel = 0;
  logic [63:0] cap_raw = '0, cap_out;

  int n_chk = 0, n_fail = 0;

  // programming history used to compute expected values
  int h_base[32], h_cnt[32];
  bit h_perm[32];
  int h_n = 0;

  bit    exp_q[$];
  int    ev_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  efilt_top #(.EVT_W(EW)) dut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(input int ev);
    bit r;
    if (h_n == 0) return 1'b1;
    r = !h_perm[0];
    for (int i = 0; i < h_n; i++)
      if (ev >= h_base[i] && ev < h_base[i] + h_cnt[i]) r = h_perm[i];
    return r;
  endfunction

  function automatic logic [63:0] exp_cap(input bit sel, input bit vn, input logic [63:0] raw);
    logic [63:0] m;
    m = '1;
    if (h_n != 0)
      for (int b = 0; b < 32; b++) begin
        m[b]      = exp_bit(sel * 32 + b);
        m[32 + b] = exp_bit(32'h4000 + sel * 32 + b);
      end
    if (sel && vn) m[31] = 1'b0;
    return raw & m;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    h_n = 0;
  endtask

  // driver: issues a command, checks its error pulse and busy length
  task automatic do_cmd(input int base, input int cnt, input logic [1:0] act,
                        input bit exp_err, input string tag);
    int nw, exp_busy, seen;
    @(negedge clk);
    cmd_valid = 1; cmd_base = EW'(base); cmd_count = (EW+1)'(cnt); cmd_act = act;
    while (!cmd_ready) @(negedge clk);
    nw = (cnt == 0) ? 0 : (((base + cnt - 1) >> 5) - (base >> 5) + 1);
    exp_busy = exp_err ? 0 : (((h_n == 0) ? NWD : 0) + ((nw > 0) ? nw + 1 : 0));
    @(negedge clk);
    cmd_valid = 0;
    check(cmd_err == exp_err, {tag, " R2 error flag"}, 64'(cmd_err), 64'(exp_err));
    if (!exp_err) begin
      h_base[h_n] = base; h_cnt[h_n] = cnt; h_perm[h_n] = (act == 2'b01); h_n++;
    end
    seen = 0;
    while (!cmd_ready) begin seen++; @(negedge clk); end
    check(seen == exp_busy, {tag, " R7 busy cycles"}, 64'(seen), 64'(exp_busy));
  endtask

  // driver: issues a lookup and pushes its expected permit into the scoreboard
  task automatic do_look(input int ev, input string tag, output int stalled);
    stalled = 0;
    @(negedge clk);
    lk_req = 1; lk_event = EW'(ev);
    while (!lk_ready) begin stalled++; @(negedge clk); end
    exp_q.push_back(exp_bit(ev)); ev_q.push_back(ev); tag_q.push_back(tag);
    @(negedge clk);
    lk_req = 0;
  endtask

  task automatic look(input int ev, input string tag);
    int s;
    do_look(ev, tag, s);
  endtask

  task automatic cap_check(input bit sel, input bit vn, input logic [63:0] raw, input string tag);
    logic [63:0] e;
    @(negedge clk);
    cap_sel = sel; ver_new = vn; cap_raw = raw;
    #1;
    e = exp_cap(sel, vn, raw);
    check(cap_out == e, tag, cap_out, e);
  endtask

  // monitor: compares each produced lookup result with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && lk_rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected lookup response", 64'(lk_permit), 64'(0));
      end else begin
        bit e; int ev; string t;
        e = exp_q.pop_front(); ev = ev_q.pop_front(); t = tag_q.pop_front();
        check(lk_permit == e, $sformatf("%s (event %0d)", t, ev), 64'(lk_permit), 64'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int st;
    do_reset();
    // reset state, filter off
    check(cmd_ready && lk_ready && !cmd_err && !lk_rsp_valid, "R1 reset outputs",
          64'({cmd_ready, lk_ready, cmd_err, lk_rsp_valid}), 64'(4'b1100));
    look(0, "R1 off permits");
    look(100, "R1 off permits");
    look(65535, "R1 off permits");
    cap_check(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R1 off capability passthrough");
    cap_check(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R10 stall bit while off");

    // refused commands
    do_cmd(10, 4, 2'b11, 1, "R2 bad action");
    do_cmd(65530, 7, 2'b01, 1, "R2 range past end");
    do_cmd(0, 1, 2'b00, 1, "R2 zero action");
    look(3, "R2 refused command leaves filter off");

    // first command permits 30..69
    do_cmd(30, 40, 2'b01, 0, "R3 first permit");
    look(29, "R3 default forbidden below");
    look(30, "R3 range start");
    look(31, "R6 word 0 tail");
    look(32, "R6 word 1 head");
    look(69, "R6 range end");
    look(70, "R3 default forbidden above");
    look(1000, "R3 default forbidden far");

    // high capability window and masking
    do_cmd(32'h4000, 5, 2'b01, 0, "R5 permit high window");
    cap_check(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R9 word 0 mask");
    cap_check(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R9 word 1 mask");
    cap_check(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R10 stall bit forced");
    cap_check(0, 1, 64'h0123_4567_89AB_CDEF, "R9 word 0 mixed raw");

    // later forbid and a zero-length command
    do_cmd(40, 10, 2'b10, 0, "R5 later forbid");
    look(39, "R5 outside forbid range kept");
    look(40, "R5 forbid start");
    look(49, "R5 forbid end");
    look(50, "R5 outside forbid range kept");
    do_cmd(5, 0, 2'b01, 0, "R5 zero count");
    look(5, "R5 zero count no change");

    // lookup and command accepted on the same edge
    fork
      do_cmd(31, 2, 2'b10, 0, "R8 same-cycle command");
      look(31, "R8 same-cycle lookup sees old table");
    join
    look(31, "R8 lookup after command sees new table");
    look(33, "R6 two-word forbid");

    // lookup raised during a long command is held
    fork
      do_cmd(100, 300, 2'b01, 0, "R8 long command");
      begin
        repeat (3) @(negedge clk);
        do_look(150, "R8 stalled lookup sees finished range", st);
        check(st > 0, "R8 lookup held while busy", 64'(st), 64'(1));
      end
    join
    look(399, "R6 multi-word end");
    look(400, "R6 multi-word past end");

    // last event boundary
    do_cmd(65535, 1, 2'b01, 0, "R6 last event");
    look(65535, "R6 last event permitted");
    look(65534, "R6 neighbour unchanged");

    // reset returns to off
    do_reset();
    look(45, "R11 reset clears filter");
    cap_check(0, 0, 64'h00FF_00FF_00FF_00FF, "R11 capability passthrough");

    // first forbid command
    do_cmd(32'h4000, 64, 2'b10, 0, "R4 first forbid");
    look(0, "R4 default permitted");
    look(32'h4000, "R4 range forbidden");
    look(32'h403F, "R4 range end forbidden");
    look(32'h4040, "R4 default permitted above");
    cap_check(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R9 word 0 high window forbidden");
    cap_check(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R10 word 1 with forbid");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all lookups answered", 64'(exp_q.size()), 64'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule